// File: doc/BRIEF.md
# Timed chip-select and sleep sequencer

This block runs the two timing commands of a serial-peripheral controller's command stream. A chip-select command drives a new pattern onto the active-low select lines, framed by a guard wait before the change and an equal guard wait after it. A sleep command simply stalls the stream for a programmed time. Commands arrive one at a time through a valid/ready handshake. The block is ready only while it is idle.

All waits are counted in prescaled units. One unit lasts (div + 1) * 2 cycles of the fast clock, where div is the prescaler value present when the command is taken. Each command also carries a short fixed overhead that the prescaler does not stretch. A chip-select command with a zero guard count skips both guard waits and completes on the next edge.

Top module: `cs_sleep_seq`

## Requirements
- R1: During and after a synchronous active-low reset, cmd_ready is 1 and every cs_n line is 1.
- R2: A command is taken on a rising edge where cmd_valid and cmd_ready are both 1. cmd_ready is 0 from that edge until the command completes, and it is 1 whenever the block is idle.
- R3: Command word: bit 15 set selects chip-select and bit 15 clear selects sleep. Bits [9:8] hold the chip-select guard count. Bits [7:0] hold the sleep count. Bits [NUM_CS-1:0] hold the new cs_n pattern.
- R4: One delay unit is (div + 1) * 2 fast cycles, where div is the prescale input sampled on the accepting edge. Changing prescale while a command runs has no effect on that command's timing.
- R5: A sleep command with count t keeps cmd_ready low for exactly 2 + t * unit cycles. A count of 0 gives 2 cycles.
- R6: A sleep command never changes cs_n.
- R7: A chip-select command with guard count t > 0 loads the pattern into cs_n on the edge 1 + t * unit cycles after acceptance. It keeps cmd_ready low for 2 + 2 * t * unit cycles in total.
- R8: A chip-select command with guard count 0 loads cs_n and returns to idle on the first edge after acceptance. cmd_ready is low for 1 cycle.
- R9: cs_n changes at most once per chip-select command, never during the second guard wait, and never while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | High while idle; command taken when both are high |
| cmd_data | input | CMD_W | Command word |
| prescale | input | DIV_W | Prescaler divider value |
| cs_n | output | NUM_CS | Registered active-low chip-select lines |

## Verification
On every cycle the assertions check the following. cs_n moves only during the first guard wait of a chip-select command. The prescaler and unit counters stay within their programmed bounds. The second-phase flag appears only for chip-select commands and is clear when idle. cmd_ready falls after each accepted command. The exact cycle counts depend on the mix of count, prescaler and command kind, so only the bench scenarios can show them. These are the busy length of each command, the edge on which the select pattern lands, the zero-count shortcut, and the immunity to a prescaler change in mid-command.

// File: rtl/cs_sleep_seq.sv
module cs_sleep_seq #(
  parameter int NUM_CS = 8,
  parameter int DIV_W  = 8,
  parameter int CMD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic [DIV_W-1:0]  prescale,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int OP_BIT = CMD_W - 1;
  localparam int PRE_W  = DIV_W + 1;
  localparam int CNT_W  = 8;

  logic              busy, is_cs, phase, fin;
  logic [CNT_W-1:0]  t_reg, unit_cnt;
  logic [NUM_CS-1:0] mask_reg;
  logic [DIV_W-1:0]  div_reg;
  logic [PRE_W-1:0]  pre_cnt;

  wire accept    = cmd_valid && !busy;
  wire unit_end  = pre_cnt == {div_reg, 1'b1};
  wire count_hit = unit_cnt == t_reg;
  wire cs_zero   = is_cs && (t_reg == '0);
  wire cs_fire   = busy && is_cs && !phase && count_hit;
  wire cs_done   = busy && is_cs && ((phase && count_hit) || cs_zero);
  wire sl_hit    = busy && !is_cs && !fin && count_hit;
  wire sl_done   = busy && !is_cs && fin;
  wire restart   = accept || (cs_fire && !cs_zero);

  assign cmd_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_cs    <= 1'b0;
      phase    <= 1'b0;
      fin      <= 1'b0;
      t_reg    <= '0;
      mask_reg <= '1;
      div_reg  <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      is_cs    <= cmd_data[OP_BIT];
      phase    <= 1'b0;
      fin      <= 1'b0;
      t_reg    <= cmd_data[OP_BIT] ? {{(CNT_W-2){1'b0}}, cmd_data[9:8]} : cmd_data[7:0];
      mask_reg <= cmd_data[NUM_CS-1:0];
      div_reg  <= prescale;
    end else if (busy) begin
      if (cs_done || sl_done) begin
        busy  <= 1'b0;
        phase <= 1'b0;
        fin   <= 1'b0;
      end else begin
        if (cs_fire) phase <= 1'b1;
        if (sl_hit)  fin   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      unit_cnt <= '0;
    end else if (restart) begin
      pre_cnt  <= '0;
      unit_cnt <= '0;
    end else if (busy && !fin) begin
      if (unit_end) begin
        pre_cnt  <= '0;
        unit_cnt <= unit_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cs_n <= '1;
    else if (cs_fire) cs_n <= mask_reg;
  end

  AST_CS_ONLY_FIRST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> $past(busy && is_cs && !phase)); // R9
  AST_CS_HOLD_SECOND_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase) |=> $stable(cs_n)); // R9
  AST_SLEEP_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_cs) |=> $stable(cs_n)); // R6
  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pre_cnt <= {div_reg, 1'b1})); // R4
  AST_UNIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (unit_cnt <= t_reg)); // R5
  AST_PHASE_CS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    phase |-> (busy && is_cs)); // R7
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R2
endmodule

// File: tb/sim_cs_sleep_seq.sv
module sim_cs_sleep_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_data = '0;
  logic [7:0]  prescale = '0;
  logic [NCS-1:0] cs_n;

  int errors = 0;
  int checks = 0;
  logic [NCS-1:0] cs_model = '1;

  typedef struct {
    int busy_len;
    int cs_at;
    int changes;
    logic [NCS-1:0] cs_val;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_sleep_seq #(.NUM_CS(NCS), .DIV_W(8), .CMD_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .prescale(prescale), .cs_n(cs_n));

  task automatic chk(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic send(input logic is_cs, input int t, input logic [NCS-1:0] mask,
                      input int div, input int later_div, input string tag);
    exp_t e;
    int unit;
    unit = (div + 1) * 2;
    if (is_cs) begin
      e.busy_len = (t == 0) ? 1 : 2 + 2 * t * unit;
      e.cs_at    = (t == 0) ? 1 : 1 + t * unit;
      e.changes  = (mask != cs_model) ? 1 : 0;
      e.cs_val   = mask;
      cs_model   = mask;
    end else begin
      e.busy_len = 2 + t * unit;
      e.cs_at    = -1;
      e.changes  = 0;
      e.cs_val   = cs_model;
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cmd_valid = 1'b1;
    cmd_data  = is_cs ? {1'b1, 5'b0, t[1:0], mask} : {8'h00, t[7:0]} | {8'h00, 8'h00};
    prescale  = div[7:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data  = 16'h0000;
    if (later_div >= 0) prescale = later_div[7:0];
  endtask

  initial begin : monitor
    exp_t e;
    string tag;
    int low, nchg, first;
    logic [NCS-1:0] prev;
    @(posedge rst_n);
    forever begin
      @(negedge clk); #(CLK_PERIOD/4);
      if (cmd_valid && cmd_ready) begin
        e = exp_q.pop_front();
        tag = tag_q.pop_front();
        prev = cs_n; low = 0; nchg = 0; first = -1;
        for (int k = 0; k < 100000; k++) begin
          @(negedge clk); #(CLK_PERIOD/4);
          if (cs_n != prev) begin
            nchg++;
            if (first < 0) first = k;
            prev = cs_n;
          end
          if (cmd_ready) break;
          low++;
        end
        chk(tag, "busy cycles", low, e.busy_len);
        chk(tag, "cs_n change count", nchg, e.changes);
        if (e.changes > 0) chk(tag, "cs_n update edge", first, e.cs_at);
        chk(tag, "final cs_n", int'(cs_n), int'(e.cs_val));
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1", "cmd_ready in reset", int'(cmd_ready), 1);
    chk("R1", "cs_n in reset", int'(cs_n), 255);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cmd_ready after reset", int'(cmd_ready), 1);
    chk("R1", "cs_n after reset", int'(cs_n), 255);

    send(1'b0, 0, '0, 0, -1, "R5");
    send(1'b0, 3, '0, 0, -1, "R5");
    send(1'b0, 5, '0, 2, -1, "R5");
    send(1'b1, 1, 8'hFE, 0, -1, "R7");
    send(1'b1, 3, 8'h5A, 1, -1, "R7");
    send(1'b0, 4, '0, 1, -1, "R6");
    send(1'b1, 0, 8'h0F, 3, -1, "R8");
    send(1'b1, 2, 8'hA5, 3, 0, "R4");
    send(1'b0, 2, '0, 1, 9, "R4");
    send(1'b1, 3, 8'hA5, 0, -1, "R9");
    send(1'b1, 0, 8'hA5, 0, -1, "R8");
    send(1'b0, 255, '0, 0, -1, "R5");
    send(1'b0, 1, '0, 255, -1, "R4");
    send(1'b1, 2, 8'h3C, 0, -1, "R3");

    @(negedge clk);
    while (!cmd_ready || exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R2", "cmd_ready while idle", int'(cmd_ready), 1);
    chk("R9", "cs_n stable while idle", int'(cs_n), int'(cs_model));
    finish_up();
  end
endmodule